// File: doc/BRIEF.md
# Audio Transmitter Control and Interrupt Unit

This unit holds the software-visible control and status state of a serial digital audio transmitter. A CPU reaches it over a small register bus. A writable control word holds three interrupt enables, a two-bit clock source code and a force-new-block request. A read-only status word holds three event flags, which are set by one-cycle pulses from the transmit data path.

The unit masks the flags with their enables and drives one registered interrupt request line. The block-done source fires only while the block flag and the data-empty flag are both set. The force-new-block bit goes to the frame sequencer. It stays set until the sequencer pulses back that a new block has begun.

Status is cleared by hardware reset, by a software reset pulse and while the stop state is held. The frame serializer, the preamble logic and the sample path sit outside this unit. They appear here only as pulse inputs.

Top module: `atx_ctrl_regs`

## Requirements
- R1: After hardware reset, both registers read 0 and `irq`, `force_block` and `clk_sel` are 0.
- R2: A write (`bus_wr`) at offset 0 stores `bus_wdata[5:0]` in the control word. Bit 0 enables the empty source, bit 1 the underrun source, bit 2 the block source, bits 4:3 hold the clock code and bit 5 is force-new-block. Reading offset 0 returns these six bits, and bits 23:6 read 0 whatever was written.
- R3: `clk_sel` always equals control bits 4:3.
- R4: `force_block` mirrors control bit 5. A `block_started` pulse clears it on the next edge, but a control write in the same cycle wins and stores `bus_wdata[5]`.
- R5: Reading offset 1 returns the status word: bit 0 data-empty, bit 1 underrun, bit 2 block-transferred, bits 23:3 zero. `empty_pulse`, `underrun_pulse` and `block_pulse` set these bits on the next edge. Writes to offset 1 change no state.
- R6: `aud_wr` clears the data-empty and block flags. A set pulse in the same cycle wins.
- R7: A read (`bus_rd`) at offset 1 clears the underrun flag. An `underrun_pulse` in the same cycle wins.
- R8: `sw_rst`, or `stop` held high, clears all status flags on the next edge and overrides set pulses. The control word is kept.
- R9: `irq` is a register loaded each cycle with (bit0 AND empty) OR (bit1 AND underrun) OR (bit2 AND block AND empty), taken from the current register contents. It therefore lags a flag or enable change by one clock.
- R10: Reads of offsets 2 and 3 return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| sw_rst | input | 1 | Software reset pulse, clears status |
| stop | input | 1 | Stop state level, holds status clear |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, used for clear-on-read |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data, combinational from bus_addr |
| aud_wr | input | 1 | Audio data register written |
| empty_pulse | input | 1 | Sets data-empty flag |
| underrun_pulse | input | 1 | Sets underrun flag |
| block_pulse | input | 1 | Sets block-transferred flag |
| block_started | input | 1 | Sequencer reports a new block began |
| clk_sel | output | 2 | Clock source code to the clock unit |
| force_block | output | 1 | Request to start a new block |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk`. They treat the strobes and event pulses as sampled one cycle at a time, and `stop` as a plain level. They make no assumption about which inputs can coincide. Collisions are therefore legal: a write together with `block_started`, a set pulse together with its clear, or `stop` together with set pulses.

The stimulus changes all inputs from one procedure, shortly after each rising edge. The random phase draws each strobe independently, so these same-cycle collisions occur often. Directed steps place the priority cases deliberately.

// File: rtl/atx_pkg.sv
package atx_pkg;
    localparam int REG_W = 24;
    localparam int CS_W  = 2;

    typedef struct packed {
        logic            blk_force;
        logic [CS_W-1:0] clk_sel;
        logic            en_blk;
        logic            en_ur;
        logic            en_empty;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic blk;
        logic ur;
        logic empty;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);
endpackage

// File: rtl/atx_ctrl_reg.sv
module atx_ctrl_reg
    import atx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wdata,
    input  logic             blk_started,
    output ctrl_t            ctrl
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl)
            ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
        else if (blk_started)
            ctrl_d.blk_force = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    // R4
    force_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_started && !wr_ctrl) |=> !ctrl_q.blk_force);

    // R4
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl_q.blk_force == $past(wdata[CTRL_W-1])));
endmodule

// File: rtl/atx_stat_flags.sv
module atx_stat_flags
    import atx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_all,
    input  logic  empty_set,
    input  logic  ur_set,
    input  logic  blk_set,
    input  logic  data_wr,
    input  logic  stat_rd,
    output stat_t stat
);
    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (clr_all) begin
            stat_d = '0;
        end else begin
            stat_d.empty = empty_set | (stat_q.empty & ~data_wr);
            stat_d.ur    = ur_set    | (stat_q.ur    & ~stat_rd);
            stat_d.blk   = blk_set   | (stat_q.blk   & ~data_wr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;

    // R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (stat_q == '0));

    // R7
    ur_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ur_set) |=> !stat_q.ur);

    // R6
    empty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !empty_set) |=> !stat_q.empty);

    // R5
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_set && !clr_all) |=> stat_q.empty);
endmodule

// File: rtl/atx_irq_gen.sv
module atx_irq_gen
    import atx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  stat_t stat,
    output logic  irq
);
    logic irq_d, irq_q;
    logic src_empty, src_ur, src_blk;

    always_comb begin
        src_empty = ctrl.en_empty & stat.empty;
        src_ur    = ctrl.en_ur    & stat.ur;
        src_blk   = ctrl.en_blk   & stat.blk & stat.empty;
        irq_d     = src_empty | src_ur | src_blk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '0) |=> !irq_q);

    // R9
    empty_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en_empty && stat.empty) |=> irq_q);

    // R9
    blk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat.empty |=> (irq_q == $past(ctrl.en_ur && stat.ur)));
endmodule

// File: rtl/atx_ctrl_regs.sv
module atx_ctrl_regs
    import atx_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int CTRL_OFS = 0,
    parameter int STAT_OFS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              stop,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              aud_wr,
    input  logic              empty_pulse,
    input  logic              underrun_pulse,
    input  logic              block_pulse,
    input  logic              block_started,
    output logic [CS_W-1:0]   clk_sel,
    output logic              force_block,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    ctrl_t ctrl;
    stat_t stat;
    logic  wr_ctrl, stat_rd, clr_all;

    assign wr_ctrl = bus_wr && (bus_addr == CTRL_A);
    assign stat_rd = bus_rd && (bus_addr == STAT_A);
    assign clr_all = sw_rst | stop;

    atx_ctrl_reg i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wdata       (bus_wdata),
        .blk_started (block_started),
        .ctrl        (ctrl)
    );

    atx_stat_flags i_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (clr_all),
        .empty_set (empty_pulse),
        .ur_set    (underrun_pulse),
        .blk_set   (block_pulse),
        .data_wr   (aud_wr),
        .stat_rd   (stat_rd),
        .stat      (stat)
    );

    atx_irq_gen i_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl  (ctrl),
        .stat  (stat),
        .irq   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_A)
            bus_rdata[CTRL_W-1:0] = ctrl;
        else if (bus_addr == STAT_A)
            bus_rdata[STAT_W-1:0] = stat;
    end

    assign clk_sel     = ctrl.clk_sel;
    assign force_block = ctrl.blk_force;

    // R2
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CTRL_A) |-> (bus_rdata[REG_W-1:CTRL_W] == '0));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr != CTRL_A) && (bus_addr != STAT_A)) |-> (bus_rdata == '0));

    // R5
    stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == STAT_A) && !block_started) |=> $stable(ctrl));
endmodule

// File: tb/test_atx_ctrl_regs.sv
`timescale 1ns/1ps
module test_atx_ctrl_regs;
    localparam int AW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sw_rst = 0, stop = 0, bus_wr = 0, bus_rd = 0, aud_wr = 0;
    logic empty_pulse = 0, underrun_pulse = 0, block_pulse = 0, block_started = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [23:0]   bus_wdata = '0;
    wire  [23:0]   bus_rdata;
    wire  [1:0]    clk_sel;
    wire           force_block, irq;

    int  total = 0, bad = 0;
    logic [5:0] m_ctrl = '0;
    logic [2:0] m_st = '0;
    logic       m_irq = 1'b0;

    always #4 clk = ~clk;

    atx_ctrl_regs i_atx_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .stop(stop),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .aud_wr(aud_wr),
        .empty_pulse(empty_pulse), .underrun_pulse(underrun_pulse),
        .block_pulse(block_pulse), .block_started(block_started),
        .clk_sel(clk_sel), .force_block(force_block), .irq(irq)
    );

    function automatic logic [23:0] exp_rd(logic [AW-1:0] a, logic [5:0] c, logic [2:0] s);
        if (a == 2'd0) return {18'd0, c};
        if (a == 2'd1) return {21'd0, s};
        return 24'd0;
    endfunction

    function automatic logic exp_irq(logic [5:0] c, logic [2:0] s);
        return (c[0] & s[0]) | (c[1] & s[1]) | (c[2] & s[2] & s[0]);
    endfunction

    task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        sw_rst = 0; stop = 0; bus_wr = 0; bus_rd = 0; aud_wr = 0;
        empty_pulse = 0; underrun_pulse = 0; block_pulse = 0; block_started = 0;
    endtask

    task automatic step();
        logic [5:0] nc;
        logic [2:0] ns;
        logic       ni;
        ni = exp_irq(m_ctrl, m_st);
        nc = m_ctrl;
        if (bus_wr && bus_addr == 2'd0) nc = bus_wdata[5:0];
        else if (block_started)         nc[5] = 1'b0;
        if (sw_rst || stop) ns = 3'b000;
        else begin
            ns[0] = empty_pulse    | (m_st[0] & ~aud_wr);
            ns[1] = underrun_pulse | (m_st[1] & ~(bus_rd && bus_addr == 2'd1));
            ns[2] = block_pulse    | (m_st[2] & ~aud_wr);
        end
        @(posedge clk);
        #2;
        m_ctrl = nc; m_st = ns; m_irq = ni;
        chk("R9 irq", {23'd0, irq}, {23'd0, m_irq});
        chk("R3 clk_sel", {22'd0, clk_sel}, {22'd0, m_ctrl[4:3]});
        chk("R4 force_block", {23'd0, force_block}, {23'd0, m_ctrl[5]});
        if (bus_addr == 2'd0)      chk("R2 ctrl read", bus_rdata, exp_rd(bus_addr, m_ctrl, m_st));
        else if (bus_addr == 2'd1) chk("R5 status read", bus_rdata, exp_rd(bus_addr, m_ctrl, m_st));
        else                       chk("R10 unmapped read", bus_rdata, 24'd0);
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h0000_5EED));
        idle();
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        bus_addr = 2'd0; #1;
        chk("R1 ctrl after reset", bus_rdata, 24'd0);
        bus_addr = 2'd1; #1;
        chk("R1 status after reset", bus_rdata, 24'd0);
        chk("R1 outputs after reset", {20'd0, irq, force_block, clk_sel}, 24'd0);
        rst_n = 1'b1;

        // R2: reserved bits read zero
        bus_addr = 2'd0; bus_wr = 1; bus_wdata = 24'hFFFFFF; step(); idle();
        chk("R2 reserved bits", bus_rdata, 24'h00003F);
        // R4: self clear by sequencer
        block_started = 1; step(); idle();
        chk("R4 cleared by block start", {23'd0, force_block}, 24'd0);
        // R4: write wins over clear
        bus_wr = 1; bus_wdata = 24'h000020; block_started = 1; step(); idle();
        chk("R4 write wins", {23'd0, force_block}, 24'd1);

        // R6: data write clears empty and block
        bus_addr = 2'd1; empty_pulse = 1; block_pulse = 1; step(); idle();
        chk("R6 flags set", bus_rdata, 24'h000005);
        aud_wr = 1; step(); idle();
        chk("R6 cleared by data write", bus_rdata, 24'h000000);
        aud_wr = 1; empty_pulse = 1; step(); idle();
        chk("R6 set wins", bus_rdata, 24'h000001);

        // R7: clear on read, set wins
        underrun_pulse = 1; step(); idle();
        bus_rd = 1; step(); idle();
        chk("R7 read clears underrun", bus_rdata & 24'h2, 24'h0);
        bus_rd = 1; underrun_pulse = 1; step(); idle();
        chk("R7 set wins over read", bus_rdata & 24'h2, 24'h2);

        // R8: stop overrides set pulses, control kept
        bus_addr = 2'd0; bus_wr = 1; bus_wdata = 24'h00001F; step(); idle();
        bus_addr = 2'd1; stop = 1; empty_pulse = 1; block_pulse = 1; step(); idle();
        chk("R8 stop clears status", bus_rdata, 24'd0);
        bus_addr = 2'd0; #1;
        chk("R8 control kept", bus_rdata, 24'h00001F);
        bus_addr = 2'd1; empty_pulse = 1; step(); idle();
        sw_rst = 1; step(); idle();
        chk("R8 sw reset clears status", bus_rdata, 24'd0);

        // R5/R10: writes to status and unmapped offsets ignored
        bus_addr = 2'd1; bus_wr = 1; bus_wdata = 24'hFFFFFF; step(); idle();
        bus_addr = 2'd3; bus_wr = 1; step(); idle();
        bus_addr = 2'd0; #1;
        chk("R5 R10 writes ignored", bus_rdata, 24'h00001F);

        for (int i = 0; i < 4000; i++) begin
            bus_addr       = AW'($urandom % 4);
            bus_wr         = ($urandom % 5) == 0;
            bus_rd         = ($urandom % 3) == 0;
            bus_wdata      = $urandom;
            aud_wr         = ($urandom % 6) == 0;
            empty_pulse    = ($urandom % 4) == 0;
            underrun_pulse = ($urandom % 5) == 0;
            block_pulse    = ($urandom % 4) == 0;
            block_started  = ($urandom % 8) == 0;
            sw_rst         = ($urandom % 64) == 0;
            stop           = ($urandom % 50) == 0;
            step();
        end
        idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule